// File: doc/BRIEF.md
# CPU-to-PCI Host Bridge Window Decoder

This block is the front end of a host bridge. It takes single accesses from a CPU-side register bus and either answers them from its own local registers or turns them into one request on a simple downstream PCI request channel. Three address windows are decoded: a control-register window, an I/O window and a memory window. Each window answers at two base addresses that differ only in address bits 31:29, so the low and high aliases behave identically.

The control-register window holds the bridge's own 256-byte configuration header, a configuration-address pointer and two translation bases, one for memory and one for I/O. Configuration cycles are indirect. Software loads the pointer, then reads or writes a data-port register, and that access becomes a 4-byte configuration request at the pointer's address. Memory and I/O accesses are translated by adding the matching base register to the offset inside the window. Byte enables come from the access size and the low address bits. Read data is returned right-justified.

The CPU issues `cpu_req` for one cycle while the block is idle. It then waits for the one-cycle `cpu_done` pulse, which carries the read data. For a read this pulse follows the downstream response. For a write it follows acceptance of the request by the downstream side.

Top module: `pcib_window_front`

## Requirements
- R1: After reset, no request is pending and `cpu_done` and `dn_valid` are low. Header word 0 reads {device ID 0x350E, vendor ID parameter} (device ID in bits 31:16). Header word 1 reads 0x02900080, so bytes 4..7 hold 0x80, 0x00, 0x90, 0x02 in little-endian order. All other header words and the pointer read zero.
- R2: A 4-byte access at register-window offsets 0x000..0x0FC reads or writes header word offset/4. Byte offset n of the word sits at bits 8n+7:8n.
- R3: Offset 0x1C0 is the configuration pointer. It reads back the value last written.
- R4: Offset 0x1C4 loads the memory base and offset 0x1C8 loads the I/O base. Both read as zero.
- R5: A 4-byte access at offset 0x220 issues a configuration request (dn_kind 0) with the pointer as address, dn_size 2 and dn_be 0xF. A write carries the CPU data. A read returns the response data.
- R6: Other offsets inside the 0x224-byte register window read zero. Writes to them change no state and issue no downstream request.
- R7: A register-window access whose cpu_size is not 2 (4 bytes) completes with zero data. It changes no register and issues no request.
- R8: Within the 16 MiB memory window, accesses of cpu_size 0/1/2 (1/2/4 bytes) issue dn_kind 1 with address equal to the window offset plus the memory base.
- R9: Within the 256 KiB I/O window, accesses of cpu_size 0/1/2 issue dn_kind 2 with address equal to the window offset plus the I/O base.
- R10: The windows decode at 0x1E200000/0xFE200000 (registers), 0x1E240000/0xFE240000 (I/O) and 0x1D000000/0xFD000000 (memory). Both aliases of a window behave identically, and no address hits two windows.
- R11: Byte enables and write lanes depend on the access size:
  - Size 0: dn_be = 1<<addr[1:0], and write data is shifted left by 8*addr[1:0].
  - Size 1: dn_be = 0x3 when addr[1] is 0 and 0xC when it is 1, and write data is shifted left by 16*addr[1].
  - Size 2: dn_be = 0xF, with no shift.
  - Reads return the response shifted right by the same amount and masked to the access width.
- R12: dn_valid stays high, with all request fields stable, until dn_ready. A write completes with cpu_done in the cycle after acceptance. A read completes in the cycle after dn_rsp_valid. A local access completes in the cycle after cpu_req. cpu_done lasts one cycle.
- R13: An address outside every window, or a memory/I/O access with cpu_size 3, completes with zero data and no downstream request. Outside a transfer, neither cpu_done nor dn_valid is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | One-cycle access request, taken while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = unsupported |
| cpu_wdata | input | 32 | Right-justified write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Right-justified read data, valid with cpu_done |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_kind | output | 2 | 0 = configuration, 1 = memory, 2 = I/O |
| dn_write | output | 1 | Request is a write |
| dn_addr | output | 32 | Translated downstream address |
| dn_size | output | 2 | Access size, same coding as cpu_size |
| dn_be | output | 4 | Byte enables |
| dn_wdata | output | 32 | Lane-aligned write data |
| dn_rsp_valid | input | 1 | Read response valid |
| dn_rsp_data | input | 32 | Lane-aligned read response data |

## Verification
The assertions check the following on every cycle:
- Requests hold stable while stalled.
- The population of byte enables matches the request size.
- Configuration requests are always full words.
- The completion pulse follows acceptance or response by exactly one cycle.
- The windows never overlap.
- The pointer changes only when it is written.

Address translation, header reset contents, write-only bases reading as zero, alias equivalence and the silence of unmapped or wrongly sized accesses are shown only by the bench's scenarios. The bench compares each of these against its own behavioural model of the register file.

// File: rtl/pcib_pkg.sv
package pcib_pkg;
  // downstream request kinds
  localparam logic [1:0] DK_CFG = 2'd0;
  localparam logic [1:0] DK_MEM = 2'd1;
  localparam logic [1:0] DK_IO  = 2'd2;

  // access size codes
  localparam logic [1:0] SZ_B   = 2'd0;
  localparam logic [1:0] SZ_H   = 2'd1;
  localparam logic [1:0] SZ_W   = 2'd2;
  localparam logic [1:0] SZ_BAD = 2'd3;

  // register-window word indices (byte offset / 4)
  localparam int IDXW = 8;
  localparam logic [IDXW-1:0] IDX_PTR    = 8'h70;
  localparam logic [IDXW-1:0] IDX_MBASE  = 8'h71;
  localparam logic [IDXW-1:0] IDX_IOBASE = 8'h72;
  localparam logic [IDXW-1:0] IDX_DPORT  = 8'h88;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } fsm_e;
endpackage

// File: rtl/pcib_win_decode.sv
module pcib_win_decode #(
  parameter int              AW         = 32,
  parameter logic [AW-1:0]   REG_BASE   = 32'h1E20_0000,
  parameter logic [AW-1:0]   REG_LEN    = 32'h0000_0224,
  parameter logic [AW-1:0]   IO_BASE    = 32'h1E24_0000,
  parameter logic [AW-1:0]   IO_LEN     = 32'h0004_0000,
  parameter logic [AW-1:0]   MEM_BASE   = 32'h1D00_0000,
  parameter logic [AW-1:0]   MEM_LEN    = 32'h0100_0000,
  parameter logic [AW-1:0]   ALIAS_FLIP = 32'hE000_0000
) (
  input  logic [AW-1:0] addr,
  output logic          hit_reg,
  output logic          hit_io,
  output logic          hit_mem,
  output logic [AW-1:0] off
);
  localparam int NWIN = 3;

  logic [NWIN-1:0] hit;
  logic [AW-1:0]   woff [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [AW-1:0] WB = (w == 0) ? REG_BASE : (w == 1) ? IO_BASE : MEM_BASE;
    localparam logic [AW-1:0] WL = (w == 0) ? REG_LEN  : (w == 1) ? IO_LEN  : MEM_LEN;
    logic [AW-1:0] o_lo, o_hi;
    logic          in_lo, in_hi;
    assign o_lo   = addr - WB;
    assign o_hi   = addr - (WB ^ ALIAS_FLIP);
    assign in_lo  = (o_lo < WL);
    assign in_hi  = (o_hi < WL);
    assign hit[w] = in_lo | in_hi;
    assign woff[w] = in_lo ? o_lo : o_hi;
  end

  assign hit_reg = hit[0];
  assign hit_io  = hit[1];
  assign hit_mem = hit[2];

  always_comb begin
    off = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (hit[w]) off = woff[w];
    end
  end
endmodule

// File: rtl/pcib_cfg_regs.sv
module pcib_cfg_regs
  import pcib_pkg::*;
#(
  parameter int               DW        = 32,
  parameter int               HDR_WORDS = 64,
  parameter logic [15:0]      VENDOR_ID = 16'h1B2C,
  parameter logic [15:0]      DEVICE_ID = 16'h350E,
  parameter logic [DW-1:0]    W1_INIT   = 32'h0290_0080
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [DW-1:0]   cfg_ptr,
  output logic [DW-1:0]   mem_base,
  output logic [DW-1:0]   io_base
);
  localparam int HW = $clog2(HDR_WORDS);

  logic [DW-1:0] hdr_w [HDR_WORDS];

  for (genvar w = 0; w < HDR_WORDS; w++) begin : g_hdr
    localparam logic [DW-1:0] INIT = (w == 0) ? DW'({DEVICE_ID, VENDOR_ID}) :
                                     (w == 1) ? W1_INIT : '0;
    logic          word_en;
    logic [DW-1:0] word_q;
    assign word_en = wr_en && (idx == IDXW'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= INIT;
      else if (word_en) word_q <= wdata;
    end
    assign hdr_w[w] = word_q;
  end

  logic ptr_en, mb_en, iob_en;
  assign ptr_en = wr_en && (idx == IDX_PTR);
  assign mb_en  = wr_en && (idx == IDX_MBASE);
  assign iob_en = wr_en && (idx == IDX_IOBASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_ptr  <= '0;
      mem_base <= '0;
      io_base  <= '0;
    end else begin
      if (ptr_en) cfg_ptr  <= wdata;
      if (mb_en)  mem_base <= wdata;
      if (iob_en) io_base  <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (idx < IDXW'(HDR_WORDS)) rdata = hdr_w[idx[HW-1:0]];
    else if (idx == IDX_PTR)    rdata = cfg_ptr;
  end

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_en |=> $stable(cfg_ptr));
endmodule

// File: rtl/pcib_lane.sv
module pcib_lane #(
  parameter int DW = 32
) (
  input  logic [1:0]      wsize,
  input  logic [1:0]      wlo,
  input  logic [DW-1:0]   wdata,
  input  logic [1:0]      rsize,
  input  logic [1:0]      rlo,
  input  logic [DW-1:0]   rsp,
  output logic [DW/8-1:0] be,
  output logic [DW-1:0]   wlane,
  output logic [DW-1:0]   rjust
);
  localparam int NB = DW / 8;

  function automatic logic [4:0] shamt(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'd0:    shamt = {lo, 3'b000};
      2'd1:    shamt = {lo[1], 4'b0000};
      default: shamt = 5'd0;
    endcase
  endfunction

  logic [4:0]    wsh, rsh;
  logic [DW-1:0] rmask;

  assign wsh = shamt(wsize, wlo);
  assign rsh = shamt(rsize, rlo);

  always_comb begin
    case (wsize)
      2'd0:    be = NB'(1) << wlo;
      2'd1:    be = wlo[1] ? NB'(4'b1100) : NB'(4'b0011);
      default: be = '1;
    endcase
    case (rsize)
      2'd0:    rmask = DW'(32'h0000_00FF);
      2'd1:    rmask = DW'(32'h0000_FFFF);
      default: rmask = '1;
    endcase
  end

  assign wlane = wdata << wsh;
  assign rjust = (rsp >> rsh) & rmask;
endmodule

// File: rtl/pcib_window_front.sv
module pcib_window_front
  import pcib_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1B2C,
  parameter logic [15:0] DEVICE_ID  = 16'h350E,
  parameter logic [31:0] W1_INIT    = 32'h0290_0080,
  parameter int          HDR_WORDS  = 64,
  parameter logic [31:0] REG_BASE   = 32'h1E20_0000,
  parameter logic [31:0] REG_LEN    = 32'h0000_0224,
  parameter logic [31:0] IO_BASE    = 32'h1E24_0000,
  parameter logic [31:0] IO_LEN     = 32'h0004_0000,
  parameter logic [31:0] MEM_BASE   = 32'h1D00_0000,
  parameter logic [31:0] MEM_LEN    = 32'h0100_0000,
  parameter logic [31:0] ALIAS_FLIP = 32'hE000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_done,
  output logic [31:0] cpu_rdata,
  output logic        dn_valid,
  input  logic        dn_ready,
  output logic [1:0]  dn_kind,
  output logic        dn_write,
  output logic [31:0] dn_addr,
  output logic [1:0]  dn_size,
  output logic [3:0]  dn_be,
  output logic [31:0] dn_wdata,
  input  logic        dn_rsp_valid,
  input  logic [31:0] dn_rsp_data
);
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NB = DW / 8;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  // decode
  logic          hit_reg, hit_io, hit_mem;
  logic [AW-1:0] off;
  logic [IDXW-1:0] idx;

  pcib_win_decode #(
    .AW(AW), .REG_BASE(REG_BASE), .REG_LEN(REG_LEN), .IO_BASE(IO_BASE),
    .IO_LEN(IO_LEN), .MEM_BASE(MEM_BASE), .MEM_LEN(MEM_LEN), .ALIAS_FLIP(ALIAS_FLIP)
  ) u_dec (
    .addr(cpu_addr), .hit_reg(hit_reg), .hit_io(hit_io), .hit_mem(hit_mem), .off(off)
  );
  assign idx = off[IDXW+1:2];

  // state
  fsm_e          st_q, st_n;
  logic [1:0]    kind_q, kind_n;
  logic          write_q, write_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [1:0]    size_q, size_n;
  logic [1:0]    lo_q, lo_n;
  logic [NB-1:0] be_q, be_n;
  logic [DW-1:0] wdata_q, wdata_n;
  logic [DW-1:0] rdata_q, rdata_n;

  logic accept, word_acc, local_wr;
  assign accept   = (st_q == ST_IDLE) && cpu_req;
  assign word_acc = accept && hit_reg && (cpu_size == SZ_W);
  assign local_wr = word_acc && cpu_we && (idx != IDX_DPORT);

  // register file
  logic [DW-1:0] reg_rdata, cfg_ptr, mem_base, io_base;
  pcib_cfg_regs #(
    .DW(DW), .HDR_WORDS(HDR_WORDS), .VENDOR_ID(VENDOR_ID),
    .DEVICE_ID(DEVICE_ID), .W1_INIT(W1_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(local_wr), .idx(idx), .wdata(cpu_wdata),
    .rdata(reg_rdata), .cfg_ptr(cfg_ptr), .mem_base(mem_base), .io_base(io_base)
  );

  // lanes
  logic [NB-1:0] lane_be;
  logic [DW-1:0] lane_wdata, lane_rjust;
  pcib_lane #(.DW(DW)) u_lane (
    .wsize(cpu_size), .wlo(cpu_addr[1:0]), .wdata(cpu_wdata),
    .rsize(size_q), .rlo(lo_q), .rsp(dn_rsp_data),
    .be(lane_be), .wlane(lane_wdata), .rjust(lane_rjust)
  );

  // next state
  always_comb begin
    st_n    = st_q;
    kind_n  = kind_q;
    write_n = write_q;
    addr_n  = addr_q;
    size_n  = size_q;
    lo_n    = lo_q;
    be_n    = be_q;
    wdata_n = wdata_q;
    rdata_n = rdata_q;
    case (st_q)
      ST_IDLE: begin
        if (cpu_req) begin
          st_n    = ST_DONE;
          rdata_n = '0;
          write_n = cpu_we;
          size_n  = cpu_size;
          lo_n    = cpu_addr[1:0];
          be_n    = lane_be;
          wdata_n = lane_wdata;
          if (hit_reg) begin
            if (cpu_size == SZ_W) begin
              if (idx == IDX_DPORT) begin
                st_n   = ST_ISSUE;
                kind_n = DK_CFG;
                addr_n = cfg_ptr;
                be_n   = '1;
              end else if (!cpu_we) begin
                rdata_n = reg_rdata;
              end
            end
          end else if ((hit_io || hit_mem) && (cpu_size != SZ_BAD)) begin
            st_n   = ST_ISSUE;
            kind_n = hit_io ? DK_IO : DK_MEM;
            addr_n = off + (hit_io ? io_base : mem_base);
          end
        end
      end
      ST_ISSUE: if (dn_ready) st_n = write_q ? ST_DONE : ST_WAIT;
      ST_WAIT: begin
        if (dn_rsp_valid) begin
          rdata_n = lane_rjust;
          st_n    = ST_DONE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q    <= ST_IDLE;
      kind_q  <= DK_CFG;
      write_q <= 1'b0;
      addr_q  <= '0;
      size_q  <= SZ_B;
      lo_q    <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q <= st_n;
      if (accept) begin
        kind_q  <= kind_n;
        write_q <= write_n;
        addr_q  <= addr_n;
        size_q  <= size_n;
        lo_q    <= lo_n;
        be_q    <= be_n;
        wdata_q <= wdata_n;
      end
      rdata_q <= rdata_n;
    end
  end

  assign cpu_done  = (st_q == ST_DONE);
  assign cpu_rdata = rdata_q;
  assign dn_valid  = (st_q == ST_ISSUE);
  assign dn_kind   = kind_q;
  assign dn_write  = write_q;
  assign dn_addr   = addr_q;
  assign dn_size   = size_q;
  assign dn_be     = be_q;
  assign dn_wdata  = wdata_q;

  // checks
  assert_dn_hold_R12: assert property (@(posedge clk) disable iff (!rst_s)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_kind) &&
      $stable(dn_be) && $stable(dn_wdata) && $stable(dn_write));
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_s)
    cpu_done |=> !cpu_done);
  assert_wr_done_R12: assert property (@(posedge clk) disable iff (!rst_s)
    dn_valid && dn_ready && dn_write |=> cpu_done);
  assert_rd_done_R12: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_WAIT) && dn_rsp_valid |=> cpu_done);
  assert_be_count_R11: assert property (@(posedge clk) disable iff (!rst_s)
    dn_valid |-> (dn_size != SZ_BAD) &&
      ($countones(dn_be) == ((dn_size == SZ_B) ? 1 : (dn_size == SZ_H) ? 2 : 4)));
  assert_cfg_word_R5: assert property (@(posedge clk) disable iff (!rst_s)
    dn_valid && (dn_kind == DK_CFG) |-> (dn_size == SZ_W) && (dn_be == 4'hF));
  assert_win_excl_R10: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({hit_reg, hit_io, hit_mem}));
endmodule

// File: tb/sim_pcib_window_front.sv
module sim_pcib_window_front;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] VID = 16'h1B2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [1:0]  cpu_size = '0;
  logic        cpu_done;
  logic [31:0] cpu_rdata;
  logic        dn_valid, dn_write;
  logic        dn_ready = 1'b0, dn_rsp_valid = 1'b0;
  logic [1:0]  dn_kind, dn_size;
  logic [31:0] dn_addr, dn_wdata;
  logic [3:0]  dn_be;
  logic [31:0] dn_rsp_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcib_window_front #(.VENDOR_ID(VID)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_size(cpu_size), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_kind(dn_kind), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_size(dn_size), .dn_be(dn_be), .dn_wdata(dn_wdata),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_data(dn_rsp_data)
  );

  int n_chk = 0, n_fail = 0;
  bit in_flight = 0, exp_dn_now = 0, finished = 0;

  // behavioural model state
  logic [31:0] hdr [64];
  logic [31:0] m_ptr, m_mb, m_iob;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // per-clock monitor: activity must match the model's expectation
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!in_flight) chk(!(cpu_done || dn_valid), "R13 idle activity", {cpu_done, dn_valid}, 0);
      else if (dn_valid && !exp_dn_now) chk(1'b0, "R6 unexpected downstream request", dn_addr, 0);
    end
  end

  task automatic xfer(input string rq, input logic we, input logic [31:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, input logic [31:0] rsp, input int lat);
    bit          dn = 0, seen = 0, got = 0;
    logic [1:0]  k = 0;
    logic [31:0] da = 0, dwd = 0, exp_rd = 0, o, mask, rd;
    logic [3:0]  be;
    int          sh, cyc;
    bit          alias_ok;

    alias_ok = (a[31:29] == 3'b000) || (a[31:29] == 3'b111);
    sh   = (sz == 0) ? 8 * a[1:0] : (sz == 1) ? 16 * a[1] : 0;
    be   = (sz == 0) ? (4'b0001 << a[1:0]) : (sz == 1) ? (a[1] ? 4'b1100 : 4'b0011) : 4'hF;
    mask = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    if (alias_ok) begin
      if (({3'b000, a[28:0]} - 32'h1E20_0000) < 32'h224) begin
        o = {3'b000, a[28:0]} - 32'h1E20_0000;
        if (sz == 2) begin
          if (o < 32'h100) begin
            if (we) hdr[o[7:2]] = wd; else exp_rd = hdr[o[7:2]];
          end else begin
            case (o & ~32'h3)
              32'h1C0: if (we) m_ptr = wd; else exp_rd = m_ptr;
              32'h1C4: if (we) m_mb = wd;
              32'h1C8: if (we) m_iob = wd;
              32'h220: begin
                dn = 1; k = 0; da = m_ptr; be = 4'hF; dwd = wd;
                exp_rd = we ? 0 : rsp;
              end
              default: ;
            endcase
          end
        end
      end else if (({3'b000, a[28:0]} - 32'h1E24_0000) < 32'h4_0000 && sz != 3) begin
        o = {3'b000, a[28:0]} - 32'h1E24_0000;
        dn = 1; k = 2; da = o + m_iob; dwd = wd << sh;
        exp_rd = we ? 0 : ((rsp >> sh) & mask);
      end else if (({3'b000, a[28:0]} - 32'h1D00_0000) < 32'h100_0000 && sz != 3) begin
        o = {3'b000, a[28:0]} - 32'h1D00_0000;
        dn = 1; k = 1; da = o + m_mb; dwd = wd << sh;
        exp_rd = we ? 0 : ((rsp >> sh) & mask);
      end
    end

    @(negedge clk);
    exp_dn_now = dn; in_flight = 1;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 0;
    cyc = 0;
    while (!got && cyc < 200) begin
      if (cpu_done) got = 1;
      else if (dn_valid && !seen) begin
        seen = 1;
        chk(dn, {rq, " request expected"}, {31'b0, dn_valid}, {31'b0, dn});
        chk(dn_kind == k, {rq, " kind"}, {30'b0, dn_kind}, {30'b0, k});
        chk(dn_addr == da, {rq, " address"}, dn_addr, da);
        chk(dn_be == be, {rq, " R11 byte enables"}, {28'b0, dn_be}, {28'b0, be});
        chk(dn_write == we, {rq, " direction"}, {31'b0, dn_write}, {31'b0, we});
        if (we) chk(dn_wdata == dwd, {rq, " R11 write lanes"}, dn_wdata, dwd);
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          chk(dn_valid && dn_addr == da, {rq, " R12 hold while stalled"}, dn_addr, da);
        end
        dn_ready = 1;
        @(negedge clk);
        dn_ready = 0;
        if (!we) begin
          chk(!cpu_done, {rq, " R12 read waits for response"}, {31'b0, cpu_done}, 0);
          dn_rsp_valid = 1; dn_rsp_data = rsp;
          @(negedge clk);
          dn_rsp_valid = 0;
        end
        chk(cpu_done, {rq, " R12 completion timing"}, {31'b0, cpu_done}, 1);
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    if (!dn) chk(cyc == 0, {rq, " R12 local completion"}, cyc, 0);
    chk(got, {rq, " completed"}, {31'b0, got}, 1);
    chk(seen == dn, {rq, " R13 request issued"}, {31'b0, seen}, {31'b0, dn});
    rd = cpu_rdata;
    chk(rd == exp_rd, {rq, " read data"}, rd, exp_rd);
    @(negedge clk);
    chk(!cpu_done, {rq, " R12 done pulse"}, {31'b0, cpu_done}, 0);
    in_flight = 0; exp_dn_now = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) hdr[i] = '0;
    hdr[0] = {16'h350E, VID};
    hdr[1] = 32'h0290_0080;
    m_ptr = 0; m_mb = 0; m_iob = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!cpu_done && !dn_valid, "R1 reset outputs", {cpu_done, dn_valid}, 0);

    // R1 reset header, R2 little-endian layout
    xfer("R1 id word", 0, 32'h1E20_0000, 2, 0, 0, 0);
    xfer("R1 word1 bytes", 0, 32'h1E20_0004, 2, 0, 0, 0);
    xfer("R1 word2 zero", 0, 32'h1E20_0008, 2, 0, 0, 0);
    xfer("R3 pointer reset", 0, 32'h1E20_01C0, 2, 0, 0, 0);
    // R2 header write, R10 alias readback
    xfer("R2 header write", 1, 32'h1E20_0010, 2, 32'hA5A5_5A5A, 0, 0);
    xfer("R10 header via alias", 0, 32'hFE20_0010, 2, 0, 0, 0);
    xfer("R2 last header word", 1, 32'hFE20_00FC, 2, 32'h0BAD_F00D, 0, 0);
    xfer("R2 last header read", 0, 32'h1E20_00FC, 2, 0, 0, 0);
    // R3 pointer
    xfer("R3 pointer write", 1, 32'h1E20_01C0, 2, 32'h8000_1234, 0, 0);
    xfer("R3 pointer read", 0, 32'h1E20_01C0, 2, 0, 0, 0);
    // R4 bases read zero
    xfer("R4 mem base write", 1, 32'h1E20_01C4, 2, 32'h4000_0000, 0, 0);
    xfer("R4 mem base read", 0, 32'h1E20_01C4, 2, 0, 0, 0);
    xfer("R4 io base write", 1, 32'hFE20_01C8, 2, 32'h0001_0000, 0, 0);
    xfer("R4 io base read", 0, 32'h1E20_01C8, 2, 0, 0, 0);
    // R5 data port
    xfer("R5 config write", 1, 32'h1E20_0220, 2, 32'hCAFE_F00D, 0, 0);
    xfer("R5 config read", 0, 32'hFE20_0220, 2, 0, 32'h1122_3344, 2);
    // R6 unused offsets
    xfer("R6 write hole", 1, 32'h1E20_0100, 2, 32'hFFFF_FFFF, 0, 0);
    xfer("R6 read hole", 0, 32'h1E20_0100, 2, 0, 0, 0);
    xfer("R6 write hole 1D0", 1, 32'h1E20_01D0, 2, 32'h1234_5678, 0, 0);
    xfer("R6 pointer intact", 0, 32'h1E20_01C0, 2, 0, 0, 0);
    xfer("R6 header intact", 0, 32'h1E20_0000, 2, 0, 0, 0);
    // R7 wrong sizes in the register window
    xfer("R7 byte read", 0, 32'h1E20_0000, 0, 0, 0, 0);
    xfer("R7 byte write", 1, 32'h1E20_0010, 0, 32'h0000_0077, 0, 0);
    xfer("R7 half write data port", 1, 32'h1E20_0220, 1, 32'h0000_BEEF, 0, 0);
    xfer("R7 header unchanged", 0, 32'h1E20_0010, 2, 0, 0, 0);
    // R8 memory window, R11 lanes
    xfer("R8 mem word write", 1, 32'h1D00_0100, 2, 32'hDEAD_BEEF, 0, 1);
    xfer("R8 mem byte read alias", 0, 32'hFD00_0003, 0, 0, 32'hAABB_CCDD, 0);
    xfer("R11 mem half read", 0, 32'h1D00_0006, 1, 0, 32'hAABB_CCDD, 3);
    xfer("R11 mem byte write lane1", 1, 32'h1DFF_FFF1, 0, 32'h0000_005C, 0, 0);
    xfer("R11 mem half read low", 0, 32'h1D00_0004, 1, 0, 32'h1357_9BDF, 0);
    // R9 I/O window
    xfer("R9 io half write", 1, 32'h1E24_0002, 1, 32'h0000_BEEF, 0, 0);
    xfer("R9 io word read alias", 0, 32'hFE24_0010, 2, 0, 32'h0F0E_0D0C, 1);
    xfer("R9 io byte read top", 0, 32'h1E27_FFFE, 0, 0, 32'h0099_0000, 0);
    // R13 unmapped and bad size
    xfer("R13 unmapped read", 0, 32'h1234_5678, 2, 0, 0, 0);
    xfer("R13 past io window", 0, 32'h1E28_0000, 2, 0, 0, 0);
    xfer("R13 bad alias bits", 0, 32'h3E20_0000, 2, 0, 0, 0);
    xfer("R13 mem size 3", 1, 32'h1D00_0000, 3, 32'h1, 0, 0);
    xfer("R12 final config read long stall", 0, 32'h1E20_0220, 2, 0, 32'h5555_AAAA, 6);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule